// File: doc/BRIEF.md
# Display Front-End Configuration Register Bank

This block holds the setup values for a display capture front end. Software writes and reads them one byte at a time over a plain parallel register port, which carries an address, write data, a write strobe and combinational read data. The active values go out as dedicated outputs. These outputs are a line-clock divider, its effective ratio, a VCO band select, a charge pump current code, a sampling phase step, and the start and length of the black-level clamp.

The 12-bit divider sits across two addresses. The upper eight bits are staged in a holding byte. The value in use changes only when the byte that carries the low four bits is written. That write moves the staged upper byte and the new low bits into the active divider together. Because of this, a line clock generator fed from the block never sees a half-updated ratio.

Top module: `fe_cfg_bank`

## Requirements
- R1: Address 0x00 reads back the revision constant (default 0x00). A write to 0x00 changes no output and no readable value.
- R2: On a synchronous active-high reset, all state returns to its default on the next rising edge. The defaults are: divider 1693 (staged upper byte 0x69, low nibble 0xD), VCO band 2'b01, pump code 3'b001, phase 5'h10, clamp start 0x08 and clamp length 0x14.
- R3: A write to 0x01 loads only the staged upper byte, which is divider bits 11..4. The active divider stays unchanged. A read of 0x01 returns the staged byte.
- R4: A write to 0x02 sets the active divider to {staged upper byte, wdata[7:4]} at that clock edge. A read of 0x02 returns the active low nibble in bits 7..4, with zeros below it.
- R5: The ratio output always equals the active divider plus one, as a 13-bit value. At divider 4095 it is 4096.
- R6: At address 0x03, bits 7..6 are the VCO band and bits 5..3 are the pump code. Bits 2..0 are not stored and read as zero.
- R7: At address 0x04, bits 7..3 are the 5-bit phase step. Bits 2..0 are not stored and read as zero.
- R8: Addresses 0x05 and 0x06 are full 8-bit registers for clamp start and clamp length.
- R9: Any address above 0x06 reads 0x00. Writes to those addresses change no output and no readable value.
- R10: Read data follows the address in the same cycle. A write becomes visible after the rising edge on which wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rdata | output | 8 | Read data for addr |
| line_div | output | 12 | Active divider register value |
| line_ratio | output | 13 | Effective division ratio, line_div + 1 |
| vco_band | output | 2 | VCO range select |
| pump_code | output | 3 | Charge pump current code |
| phase_step | output | 5 | Sampling phase, one of 32 steps |
| clamp_start | output | 8 | Clamp placement in pixel periods |
| clamp_len | output | 8 | Clamp duration in pixel periods |

## Verification
Every cycle, the assertions check four things. The active divider never moves except on a low-nibble write. A commit loads exactly the staged byte and the written nibble. The revision address and the unmapped addresses read zero. Field writes land in the right bits. The ratio arithmetic at its extremes needs the bench's scenarios, and so do defaults restored by a mid-run reset and the fact that ignored writes disturb nothing. The bench runs a behavioural model and compares against it every cycle, through directed writes and a pseudo-random write sequence.

// File: rtl/fe_cfg_bank.sv
module fe_cfg_bank #(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] REV_ID    = 8'h00,
  parameter logic [11:0] DIV_RST  = 12'd1693,
  parameter logic [1:0] VCO_RST   = 2'b01,
  parameter logic [2:0] PUMP_RST  = 3'b001,
  parameter logic [4:0] PHASE_RST = 5'h10,
  parameter logic [7:0] CPOS_RST  = 8'h08,
  parameter logic [7:0] CLEN_RST  = 8'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  output logic [7:0]        rdata,
  output logic [11:0]       line_div,
  output logic [12:0]       line_ratio,
  output logic [1:0]        vco_band,
  output logic [2:0]        pump_code,
  output logic [4:0]        phase_step,
  output logic [7:0]        clamp_start,
  output logic [7:0]        clamp_len
);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIVH = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIVL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ANLG = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PHS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CPOS = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CLEN = ADDR_W'(6);

  logic [7:0] hi_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_stage    <= DIV_RST[11:4];
      line_div    <= DIV_RST;
      vco_band    <= VCO_RST;
      pump_code   <= PUMP_RST;
      phase_step  <= PHASE_RST;
      clamp_start <= CPOS_RST;
      clamp_len   <= CLEN_RST;
    end else if (wr_en) begin
      case (addr)
        A_DIVH: hi_stage <= wdata;
        A_DIVL: line_div <= {hi_stage, wdata[7:4]};
        A_ANLG: begin
          vco_band  <= wdata[7:6];
          pump_code <= wdata[5:3];
        end
        A_PHS:  phase_step  <= wdata[7:3];
        A_CPOS: clamp_start <= wdata;
        A_CLEN: clamp_len   <= wdata;
        default: ;
      endcase
    end
  end

  assign line_ratio = {1'b0, line_div} + 13'd1;

  always_comb begin
    case (addr)
      A_REV:   rdata = REV_ID;
      A_DIVH:  rdata = hi_stage;
      A_DIVL:  rdata = {line_div[3:0], 4'b0000};
      A_ANLG:  rdata = {vco_band, pump_code, 3'b000};
      A_PHS:   rdata = {phase_step, 3'b000};
      A_CPOS:  rdata = clamp_start;
      A_CLEN:  rdata = clamp_len;
      default: rdata = 8'h00;
    endcase
  end

  p_rev_read_r1: assert property (@(posedge clk) disable iff (rst)
    addr == A_REV |-> rdata == REV_ID);

  p_reset_div_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_div == DIV_RST && hi_stage == DIV_RST[11:4]));

  p_div_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_DIVL) |=> $stable(line_div));

  p_div_commit_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DIVL) |=> line_div == {$past(hi_stage), $past(wdata[7:4])});

  p_anlg_fields_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ANLG) |=> (vco_band == $past(wdata[7:6]) && pump_code == $past(wdata[5:3])));

  p_phase_field_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_PHS) |=> phase_step == $past(wdata[7:3]));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    addr > A_CLEN |-> rdata == 8'h00);
endmodule

// File: tb/tb_fe_cfg_bank.sv
`timescale 1ns/1ps
module tb_fe_cfg_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr_en = 1'b0;
  logic [7:0] rdata;
  logic [11:0] line_div;
  logic [12:0] line_ratio;
  logic [1:0] vco_band;
  logic [2:0] pump_code;
  logic [4:0] phase_step;
  logic [7:0] clamp_start, clamp_len;

  int checks = 0, failures = 0;
  int m_div, m_hi, m_vco, m_pump, m_phs, m_cpos, m_clen;

  always #10 clk = ~clk;

  fe_cfg_bank dut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .line_div(line_div), .line_ratio(line_ratio), .vco_band(vco_band),
    .pump_code(pump_code), .phase_step(phase_step), .clamp_start(clamp_start),
    .clamp_len(clamp_len));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return 0;
      1: return m_hi;
      2: return (m_div % 16) * 16;
      3: return m_vco * 64 + m_pump * 8;
      4: return m_phs * 8;
      5: return m_cpos;
      6: return m_clen;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_div = 1693; m_hi = 'h69; m_vco = 1; m_pump = 1; m_phs = 'h10;
    m_cpos = 'h08; m_clen = 'h14;
  endtask

  task automatic cmp_outputs();
    chk("R4 line_div", int'(line_div), m_div);
    chk("R5 line_ratio", int'(line_ratio), m_div + 1);
    chk("R6 vco_band", int'(vco_band), m_vco);
    chk("R6 pump_code", int'(pump_code), m_pump);
    chk("R7 phase_step", int'(phase_step), m_phs);
    chk("R8 clamp_start", int'(clamp_start), m_cpos);
    chk("R8 clamp_len", int'(clamp_len), m_clen);
  endtask

  // one clock: drive, check read (R10), clock, update model, check outputs
  task automatic cyc(int a, int d, bit we, bit r = 1'b0);
    @(negedge clk);
    addr = 8'(a); wdata = 8'(d); wr_en = we; rst = r;
    #2;
    chk($sformatf("R10 rdata@%0h", a), int'(rdata), m_read(a));
    @(posedge clk);
    if (r) m_reset();
    else if (we) begin
      case (a)
        1: m_hi = d;
        2: m_div = m_hi * 16 + d / 16;
        3: begin m_vco = d / 64; m_pump = (d / 8) % 8; end
        4: m_phs = d / 8;
        5: m_cpos = d;
        6: m_clen = d;
        default: ;
      endcase
    end
    #2;
    cmp_outputs();
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lfsr;
    m_reset();
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    // R2 defaults
    chk("R2 div reset", int'(line_div), 1693);
    chk("R2 ratio reset", int'(line_ratio), 1694);
    cyc(1, 0, 0);
    chk("R2 staged byte", int'(rdata), 'h69);
    // R1 revision and ignored write
    cyc(0, 'hFF, 1);
    cyc(0, 0, 0);
    chk("R1 rev after write", int'(rdata), 0);
    // R3 staged high write holds active
    cyc(1, 'hAB, 1);
    chk("R3 active held", int'(line_div), 1693);
    cyc(1, 0, 0);
    chk("R3 staged readback", int'(rdata), 'hAB);
    // R4 commit
    cyc(2, 'hC7, 1);
    chk("R4 commit", int'(line_div), 'hABC);
    cyc(2, 0, 0);
    chk("R4 low readback", int'(rdata), 'hC0);
    // R5 extremes
    cyc(1, 'hFF, 1); cyc(2, 'hF0, 1);
    chk("R5 max ratio", int'(line_ratio), 4096);
    cyc(1, 'h00, 1); cyc(2, 'h0F, 1);
    chk("R5 min ratio", int'(line_ratio), 1);
    // R6 R7 unused bits
    cyc(3, 'hFF, 1); cyc(3, 0, 0);
    chk("R6 readback", int'(rdata), 'hF8);
    cyc(4, 'hFF, 1); cyc(4, 0, 0);
    chk("R7 readback", int'(rdata), 'hF8);
    cyc(3, 'h5A, 1);
    chk("R6 pump field", int'(pump_code), 3);
    // R8 clamps
    cyc(5, 'hE1, 1); cyc(6, 'h3C, 1);
    chk("R8 start", int'(clamp_start), 'hE1);
    chk("R8 len", int'(clamp_len), 'h3C);
    // R9 unmapped
    for (int a = 7; a < 256; a += 31) cyc(a, 'hA5, 1);
    cyc(255, 'h5A, 1);
    cyc(7, 0, 0);
    chk("R9 unmapped read", int'(rdata), 0);
    // mid-run reset (R2)
    cyc(0, 0, 0, 1);
    chk("R2 reset vco", int'(vco_band), 1);
    chk("R2 reset phase", int'(phase_step), 'h10);
    // pseudo-random traffic
    lfsr = 'h1D3;
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      cyc(lfsr % 9, (lfsr >> 5) & 'hFF, lfsr[3]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule